// File: doc/BRIEF.md
# Infrared Receive Byte Queue with Event Interrupt

This block sits after an infrared pulse-width encoder. Each run-length byte the encoder produces is pushed into a 16-entry queue. Software takes the bytes out one at a time through a data register. A status word gives the fill level of the queue and three sticky events: the queue overflowed, the encoder signalled the end of a packet, and the queue reached its fill trigger.

An interrupt-enable word holds one enable bit for each event and a 4-bit trigger field. The trigger field is programmed as the desired level minus one. The single interrupt line is level-sensitive and stays high while any enabled event is pending. Software reads the status word and clears the events it has handled by writing ones to their bits. The register bus is a plain read strobe and a plain write strobe with a word address. Read data is returned combinationally in the cycle of the read strobe.

Top module: `ir_rx_fifo_irq`

## Requirements
- R1: The queue holds 16 bytes in arrival order. A push while 16 bytes are stored is dropped, even if a pop happens in the same cycle.
- R2: A read of the status word (address 0x4) returns the fill level, 0 to 16, in bits 13:8. All bits not named in R2, R3, R5 and R7 read as zero.
- R3: A push while the queue is full sets the overflow event, status bit 0, on the next clock edge. The event stays set until software clears it.
- R4: A read of the data register (address 0x0) returns the oldest byte in bits 7:0 and removes it. A read while the queue is empty returns zero and leaves the fill level unchanged.
- R5: A one-cycle pulse on `pkt_end` sets the packet-end event, status bit 1, on the next edge. This happens whatever the queue holds.
- R6: The interrupt-enable word (address 0x8) is written and read back. Bit 0 enables overflow, bit 1 enables packet end, bit 4 enables data available, and bits 11:8 hold the trigger field. It resets to zero.
- R7: On every edge where the fill level before that edge is at least the trigger field plus one, the data-available event, status bit 4, is set.
- R8: A write to the status word clears each event whose bit is written as one. Writing 0xFF clears all three. A set condition in the same cycle as a clear takes priority, so the event stays set.
- R9: `irq` is high exactly when some pending event has its enable bit set. With the enable word at zero, `irq` stays low.
- R10: A push and a pop in the same cycle while the queue is not full both take effect. The fill level is unchanged and the order is kept.
- R11: Reads or writes to any other address have no effect on the queue, the events or the enable word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Encoder byte strobe |
| push_data | input | 8 | Encoder run-length byte |
| pkt_end | input | 1 | Encoder end-of-packet pulse |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 4 | Register byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid while bus_rd is high |
| irq | output | 1 | Level interrupt |

## Verification
Several functions of this block can fall in the same cycle. One case is an encoder push at the same edge as a data-register pop, both when the queue is part-filled and when it is full. The other is an event being set at the same edge as software writes a one to clear it. The bench drives these collisions on purpose. It pairs `pkt_end` with a 0xFF status write, and it pairs a full-queue push with a pop. A behavioural queue model, updated on every clock, decides each outcome: the fill level stays unchanged or the push is dropped, and the event survives the clear. The next status read and the `irq` line are then compared against that model.

// File: rtl/ir_rx_pkg.sv
package ir_rx_pkg;
   // register word offsets
   localparam int OFF_DATA = 'h0;
   localparam int OFF_STAT = 'h4;
   localparam int OFF_IEN  = 'h8;

   // event indices and their bit positions in status / enable words
   localparam int EVT_N   = 3;
   localparam int EVT_OVF = 0;
   localparam int EVT_PKT = 1;
   localparam int EVT_DAV = 2;
   localparam int EVT_POS [EVT_N] = '{0, 1, 4};

   localparam int CNT_LSB = 8;   // fill level field in status
   localparam int LVL_LSB = 8;   // trigger field in enable word

   typedef logic [EVT_N-1:0] evt_vec_t;
endpackage

// File: rtl/ir_rx_store.sv
module ir_rx_store #(
   parameter int DATA_W = 8,
   parameter int DEPTH  = 16,
   localparam int PTR_W = $clog2(DEPTH),
   localparam int CNT_W = PTR_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_req,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              rd_req,
   output logic [DATA_W-1:0] rd_data,
   output logic [CNT_W-1:0]  fill,
   output logic              full,
   output logic              empty
);
   logic [DATA_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr, rptr;
   logic              do_wr, do_rd;

   assign full  = (fill == CNT_W'(DEPTH));
   assign empty = (fill == '0);
   assign do_wr = wr_req && !full;
   assign do_rd = rd_req && !empty;
   assign rd_data = empty ? '0 : mem[rptr];

   always_ff @(posedge clk) begin
      if (do_wr) mem[wptr] <= wr_data;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr <= '0;
         rptr <= '0;
         fill <= '0;
      end else begin
         if (do_wr) wptr <= wptr + 1'b1;
         if (do_rd) rptr <= rptr + 1'b1;
         case ({do_wr, do_rd})
            2'b10:   fill <= fill + 1'b1;
            2'b01:   fill <= fill - 1'b1;
            default: fill <= fill;
         endcase
      end
   end
endmodule

// File: rtl/ir_rx_events.sv
module ir_rx_events #(
   parameter int NUM = 3
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic [NUM-1:0] set,
   input  logic [NUM-1:0] clr,
   output logic [NUM-1:0] pend
);
   for (genvar i = 0; i < NUM; i++) begin : g_evt
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      pend[i] <= 1'b0;
         else if (set[i]) pend[i] <= 1'b1;
         else if (clr[i]) pend[i] <= 1'b0;
      end
   end
endmodule

// File: rtl/ir_rx_fifo_irq.sv
module ir_rx_fifo_irq
   import ir_rx_pkg::*;
#(
   parameter int DATA_W    = 8,
   parameter int DEPTH     = 16,
   parameter int ADDR_W    = 4,
   parameter int BUS_W     = 32,
   parameter int LVL_W     = 4,
   parameter int CNT_FLD_W = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              push_valid,
   input  logic [DATA_W-1:0] push_data,
   input  logic              pkt_end,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic [BUS_W-1:0]  bus_rdata,
   output logic              irq
);
   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (CNT_W > CNT_FLD_W) begin : g_bad_cnt
      $error("fill level does not fit its status field");
   end
   if ((1 << LVL_W) < DEPTH) begin : g_bad_lvl
      $error("trigger field cannot reach DEPTH");
   end
   if (BUS_W < CNT_LSB + CNT_FLD_W || BUS_W < LVL_LSB + LVL_W || DATA_W > BUS_W) begin : g_bad_bus
      $error("bus too narrow for the register layout");
   end

   // address decode
   logic sel_data, sel_stat, sel_ien;
   assign sel_data = (bus_addr == ADDR_W'(OFF_DATA));
   assign sel_stat = (bus_addr == ADDR_W'(OFF_STAT));
   assign sel_ien  = (bus_addr == ADDR_W'(OFF_IEN));

   // byte queue
   logic [DATA_W-1:0] q_head;
   logic [CNT_W-1:0]  fill_cnt;
   logic              q_full, q_empty;

   ir_rx_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_req  (push_valid),
      .wr_data (push_data),
      .rd_req  (bus_rd && sel_data),
      .rd_data (q_head),
      .fill    (fill_cnt),
      .full    (q_full),
      .empty   (q_empty)
   );

   // enable word
   evt_vec_t         ien_mask;
   logic [LVL_W-1:0] ien_lvl;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ien_mask <= '0;
         ien_lvl  <= '0;
      end else if (bus_wr && sel_ien) begin
         for (int i = 0; i < EVT_N; i++) ien_mask[i] <= bus_wdata[EVT_POS[i]];
         ien_lvl <= bus_wdata[LVL_LSB +: LVL_W];
      end
   end

   // event flags
   logic [CNT_W:0] trig_thr;
   evt_vec_t       evt_set, evt_clr, evt_pend;

   assign trig_thr = (CNT_W+1)'(ien_lvl) + 1'b1;
   assign evt_set[EVT_OVF] = push_valid && q_full;
   assign evt_set[EVT_PKT] = pkt_end;
   assign evt_set[EVT_DAV] = ({1'b0, fill_cnt} >= trig_thr);

   for (genvar i = 0; i < EVT_N; i++) begin : g_clr
      assign evt_clr[i] = bus_wr && sel_stat && bus_wdata[EVT_POS[i]];
   end

   ir_rx_events #(.NUM(EVT_N)) u_events (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (evt_set),
      .clr   (evt_clr),
      .pend  (evt_pend)
   );

   // read words
   logic [BUS_W-1:0] stat_word, ien_word, data_word;

   always_comb begin
      stat_word = '0;
      stat_word[CNT_LSB +: CNT_FLD_W] = CNT_FLD_W'(fill_cnt);
      ien_word = '0;
      ien_word[LVL_LSB +: LVL_W] = ien_lvl;
      for (int i = 0; i < EVT_N; i++) begin
         stat_word[EVT_POS[i]] = evt_pend[i];
         ien_word[EVT_POS[i]]  = ien_mask[i];
      end
      data_word = '0;
      data_word[DATA_W-1:0] = q_head;
   end

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_data)      bus_rdata = data_word;
         else if (sel_stat) bus_rdata = stat_word;
         else if (sel_ien)  bus_rdata = ien_word;
      end
   end

   assign irq = |(evt_pend & ien_mask);

   logic unused_q_empty;
   assign unused_q_empty = q_empty;
endmodule

// File: rtl/ir_rx_fifo_irq_chk.sv
module ir_rx_fifo_irq_chk #(
   parameter int DEPTH  = 16,
   parameter int ADDR_W = 4,
   parameter int BUS_W  = 32,
   parameter int CNT_W  = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              push_valid,
   input logic              pkt_end,
   input logic              bus_rd,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [BUS_W-1:0]  bus_rdata,
   input logic              irq,
   input logic [CNT_W-1:0]  fill,
   input logic [2:0]        pend,
   input logic [2:0]        mask
);
   logic data_rd;
   assign data_rd = bus_rd && (bus_addr == '0);

   p_fill_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      fill <= CNT_W'(DEPTH));

   p_full_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CNT_W'(DEPTH) && push_valid && !data_rd) |=> fill == CNT_W'(DEPTH));

   p_ovf_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (fill == CNT_W'(DEPTH) && push_valid) |=> pend[0]);

   p_empty_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && fill == '0) |-> bus_rdata == '0);

   p_empty_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && fill == '0 && !push_valid) |=> fill == '0);

   p_pkt_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
      pkt_end |=> pend[1]);

   p_irq_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (mask == '0) |-> !irq);

   p_irq_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> (pend & mask) != '0);
endmodule

bind ir_rx_fifo_irq ir_rx_fifo_irq_chk #(
   .DEPTH(DEPTH), .ADDR_W(ADDR_W), .BUS_W(BUS_W), .CNT_W(CNT_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .push_valid (push_valid),
   .pkt_end    (pkt_end),
   .bus_rd     (bus_rd),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .irq        (irq),
   .fill       (fill_cnt),
   .pend       (evt_pend),
   .mask       (ien_mask)
);

// File: tb/ir_rx_fifo_irq_tb.sv
module ir_rx_fifo_irq_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        push_valid = 1'b0;
   logic [7:0]  push_data = '0;
   logic        pkt_end = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq;

   always #2.5 clk = ~clk;

   ir_rx_fifo_irq u_dut (
      .clk(clk), .rst_n(rst_n), .push_valid(push_valid), .push_data(push_data),
      .pkt_end(pkt_end), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
      .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
   );

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // behavioural model
   logic [7:0] mq[$];
   bit m_ovf, m_pkt, m_dav;
   bit e_ovf, e_pkt, e_dav;
   int m_lvl;

   function automatic logic [31:0] m_read(input logic [3:0] a);
      logic [31:0] w = '0;
      if (a == 4'h0) begin
         if (mq.size() > 0) w[7:0] = mq[0];
      end else if (a == 4'h4) begin
         w[13:8] = 6'(mq.size());
         w[0] = m_ovf; w[1] = m_pkt; w[4] = m_dav;
      end else if (a == 4'h8) begin
         w[11:8] = 4'(m_lvl);
         w[0] = e_ovf; w[1] = e_pkt; w[4] = e_dav;
      end
      return w;
   endfunction

   function automatic bit m_irq();
      return (m_ovf && e_ovf) || (m_pkt && e_pkt) || (m_dav && e_dav);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic model_edge();
      int sz = mq.size();
      bit pop = bus_rd && bus_addr == 4'h0 && sz > 0;
      bit clr = bus_wr && bus_addr == 4'h4;
      bit s_ovf = push_valid && sz == 16;
      bit s_dav = sz >= m_lvl + 1;
      m_ovf = s_ovf ? 1'b1 : ((clr && bus_wdata[0]) ? 1'b0 : m_ovf);
      m_pkt = pkt_end ? 1'b1 : ((clr && bus_wdata[1]) ? 1'b0 : m_pkt);
      m_dav = s_dav ? 1'b1 : ((clr && bus_wdata[4]) ? 1'b0 : m_dav);
      if (bus_wr && bus_addr == 4'h8) begin
         e_ovf = bus_wdata[0]; e_pkt = bus_wdata[1]; e_dav = bus_wdata[4];
         m_lvl = int'(bus_wdata[11:8]);
      end
      if (pop) void'(mq.pop_front());
      if (push_valid && sz < 16) mq.push_back(push_data);
   endtask

   // one bus/encoder cycle, compared against the model
   task automatic step(input bit pv, input logic [7:0] pd, input bit pe,
                       input bit wr, input bit rd, input logic [3:0] a,
                       input logic [31:0] wd, input string tag);
      @(negedge clk);
      push_valid = pv; push_data = pd; pkt_end = pe;
      bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = wd;
      #1;
      if (rd) chk(tag, bus_rdata, m_read(a));
      chk({tag, "/R9 irq"}, {31'b0, irq}, {31'b0, m_irq()});
      @(posedge clk);
      model_edge();
   endtask

   task automatic idle(input string tag);
      step(0, 0, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic push(input logic [7:0] d, input string tag);
      step(1, d, 0, 0, 0, 0, 0, tag);
   endtask
   task automatic rd(input logic [3:0] a, input string tag);
      step(0, 0, 0, 0, 1, a, 0, tag);
   endtask
   task automatic wr(input logic [3:0] a, input logic [31:0] d, input string tag);
      step(0, 0, 0, 1, 0, a, d, tag);
   endtask

   initial begin
      m_lvl = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // reset state
      rd(4'h4, "R2 reset status");
      rd(4'h8, "R6 reset enable");
      rd(4'h0, "R4 reset empty read");
      // enable all, trigger at 8 (field 7)
      wr(4'h8, 32'h0000_0713, "R6 write enable");
      rd(4'h8, "R6 readback");
      // unmapped address has no effect
      wr(4'hC, 32'hFFFF_FFFF, "R11 stray write");
      rd(4'h8, "R11 enable unchanged");
      rd(4'hC, "R11 stray read");
      // few bytes, order
      for (int i = 0; i < 5; i++) push(8'h80 + 8'(i), "R1 push");
      rd(4'h4, "R2 count five");
      rd(4'h0, "R4 oldest byte");
      rd(4'h0, "R4 second byte");
      // simultaneous push and pop
      step(1, 8'h5A, 0, 0, 1, 4'h0, 0, "R10 push+pop");
      rd(4'h4, "R10 count held");
      // fill to trigger and beyond
      for (int i = 0; i < 13; i++) push(8'h10 + 8'(i), "R7 fill");
      idle("R7 settle");
      rd(4'h4, "R7 dav and full count");
      // overflow: push while full, also with a pop in the same cycle
      push(8'hEE, "R3 push when full");
      rd(4'h4, "R3 overflow flag");
      step(1, 8'hDD, 0, 0, 1, 4'h0, 0, "R1 full push with pop");
      rd(4'h4, "R1 count after drop");
      // W1C individual, then overflow stays sticky
      wr(4'h4, 32'h0000_0001, "R8 clear overflow");
      rd(4'h4, "R8 after clear");
      // drain everything and one extra
      for (int i = 0; i < 16; i++) rd(4'h0, "R4 drain");
      rd(4'h0, "R4 empty read");
      rd(4'h4, "R4 count after empty read");
      // packet end with empty queue
      step(0, 0, 1, 0, 0, 0, 0, "R5 pulse");
      rd(4'h4, "R5 packet flag");
      wr(4'h4, 32'h0000_00FF, "R8 clear all");
      rd(4'h4, "R8 all clear");
      // clear collides with set: set wins
      step(0, 0, 1, 1, 0, 4'h4, 32'h0000_00FF, "R8 set vs clear");
      rd(4'h4, "R8 set wins");
      // masking
      wr(4'h8, 32'h0, "R9 mask all");
      idle("R9 masked");
      rd(4'h4, "R9 flag still pending");
      // trigger at 1 (field 0): dav after one byte
      wr(4'h4, 32'h0000_00FF, "R8 clear");
      wr(4'h8, 32'h0000_0010, "R7 level one");
      push(8'h42, "R7 one byte");
      idle("R7 wait");
      rd(4'h4, "R7 dav at one");
      rd(4'h0, "R4 pop last");
      wr(4'h4, 32'h0000_0010, "R8 clear dav");
      rd(4'h4, "R8 dav cleared");
      idle("end");
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule